// File: doc/BRIEF.md
# Branch Target Address Generator

This unit produces the next 16-bit program counter of an 8051-style core once per clock. The decode stage supplies the branch kind, the length of the current instruction and a taken qualifier. The fetch stage supplies the operand bytes: a signed 8-bit displacement, an 11-bit in-page address or a 16-bit absolute address. The accumulator and the data pointer are also supplied, for table jumps. The unit computes every candidate target in parallel, picks one, and registers it as the new program counter.

Every target is formed from the incremented address (current PC plus instruction length), except the absolute and table targets. A relative target adds the sign-extended displacement to the incremented address. An in-page target keeps the top five bits of the incremented address and replaces the rest. All sums wrap within the 64KB code space.

Top module: `bta_nextpc`

## Requirements
- R1: A synchronous active-high `rst` loads `pc_q` with 0000H at the next rising edge, whatever the other inputs are.
- R2: When `kind` is 0 (sequential), `pc_q` becomes `pc_q + ilen`, where `ilen` is the 2-bit instruction length. Unused kind codes 5, 6 and 7 behave the same way.
- R3: When `taken` is 0, `pc_q` becomes `pc_q + ilen` for every kind.
- R4: When `kind` is 1 (relative) and `taken` is 1, `pc_q` becomes `pc_q + ilen + sext(rel_off)`.
- R5: `rel_off` is two's complement. 80H adds -128, 7FH adds +127 and FEH adds -2, so the target lies within -128..+127 of the incremented address.
- R6: When `kind` is 2 (in-page) and `taken` is 1, bits 15:11 of `pc_q` come from `pc_q + ilen` and bits 10:0 come from `page_addr`.
- R7: When `kind` is 3 (long) and `taken` is 1, `pc_q` becomes `abs_addr`.
- R8: When `kind` is 4 (table) and `taken` is 1, `pc_q` becomes `dptr` plus the zero-extended `acc`.
- R9: All address sums wrap modulo 65536. For example, FFFFH + 1 gives 0000H, and FF80H + FFH gives 007FH.
- R10: `pc_q` changes only at a rising clock edge and reflects the inputs sampled at that edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kind | input | 3 | Branch kind: 0 seq, 1 rel, 2 page, 3 long, 4 table |
| ilen | input | 2 | Current instruction length in bytes |
| taken | input | 1 | Branch condition met |
| rel_off | input | 8 | Signed relative displacement |
| page_addr | input | 11 | In-page target bits |
| abs_addr | input | 16 | Absolute target |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| pc_q | output | 16 | Registered program counter |

## Verification
Every result appears on `pc_q` exactly one rising edge after the inputs that produce it. The bench drives the inputs on the falling edge and compares `pc_q` on the following falling edge, just before it drives the next set. Its reference model keeps its own PC copy and advances that copy in step with the design, so each comparison pairs one stimulus with the single register stage it passed through. Directed cases cover the displacement extremes, page-boundary crossing, wrap at FFFFH and reset in mid-run. Seeded random steps cover the remaining input combinations.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef enum logic [2:0] {
    BK_SEQ   = 3'd0,
    BK_REL   = 3'd1,
    BK_PAGE  = 3'd2,
    BK_LONG  = 3'd3,
    BK_TABLE = 3'd4
  } br_kind_e;
endpackage

// File: rtl/bta_incr.sv
module bta_incr #(
  parameter int AW = 16,
  parameter int LW = 2
) (
  input  logic [AW-1:0] pc,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] inc
);
  localparam int PADW = AW - LW;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] a, input logic [LW-1:0] n);
    return a + {{PADW{1'b0}}, n};
  endfunction

  assign inc = advance(pc, len);
endmodule

// File: rtl/bta_targets.sv
module bta_targets #(
  parameter int AW = 16,
  parameter int OW = 8,
  parameter int PW = 11,
  parameter int DW = 8
) (
  input  logic [AW-1:0] inc,
  input  logic [OW-1:0] off,
  input  logic [PW-1:0] page,
  input  logic [DW-1:0] acc,
  input  logic [AW-1:0] dptr,
  output logic [AW-1:0] t_rel,
  output logic [AW-1:0] t_page,
  output logic [AW-1:0] t_tab
);
  localparam int SXW = AW - OW;
  localparam int ZXW = AW - DW;
  localparam int HIW = AW - PW;

  function automatic logic [AW-1:0] rel_sum(input logic [AW-1:0] base, input logic [OW-1:0] d);
    return base + {{SXW{d[OW-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] page_merge(input logic [HIW-1:0] hi, input logic [PW-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [AW-1:0] tab_sum(input logic [DW-1:0] a, input logic [AW-1:0] p);
    return p + {{ZXW{1'b0}}, a};
  endfunction

  assign t_rel  = rel_sum(inc, off);
  assign t_page = page_merge(inc[AW-1:PW], page);
  assign t_tab  = tab_sum(acc, dptr);
endmodule

// File: rtl/bta_select.sv
module bta_select
  import bta_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [2:0]    kind,
  input  logic          taken,
  input  logic [AW-1:0] inc,
  input  logic [AW-1:0] t_rel,
  input  logic [AW-1:0] t_page,
  input  logic [AW-1:0] t_long,
  input  logic [AW-1:0] t_tab,
  output logic [AW-1:0] nxt,
  output logic          jump
);
  br_kind_e k;
  assign k = br_kind_e'(kind);

  always_comb begin
    nxt  = inc;
    jump = 1'b0;
    if (taken) begin
      unique case (k)
        BK_REL:   begin nxt = t_rel;  jump = 1'b1; end
        BK_PAGE:  begin nxt = t_page; jump = 1'b1; end
        BK_LONG:  begin nxt = t_long; jump = 1'b1; end
        BK_TABLE: begin nxt = t_tab;  jump = 1'b1; end
        default:  begin nxt = inc;    jump = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/bta_pc_reg.sv
module bta_pc_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= nxt;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (pc_q == '0)); // R1
  AST_LOADS_NEXT: assert property (@(posedge clk) disable iff (rst) !rst |=> (pc_q == $past(nxt))); // R10
endmodule

// File: rtl/bta_nextpc.sv
module bta_nextpc
  import bta_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 2,
  parameter int OW = 8,
  parameter int PW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    kind,
  input  logic [LW-1:0] ilen,
  input  logic          taken,
  input  logic [OW-1:0] rel_off,
  input  logic [PW-1:0] page_addr,
  input  logic [AW-1:0] abs_addr,
  input  logic [DW-1:0] acc,
  input  logic [AW-1:0] dptr,
  output logic [AW-1:0] pc_q
);
  localparam int HIW = AW - PW;

  logic [AW-1:0] inc_pc;
  logic [AW-1:0] t_rel, t_page, t_tab;
  logic [AW-1:0] nxt_pc;
  logic          jump_sel;

  bta_incr #(.AW(AW), .LW(LW)) u_incr (
    .pc(pc_q), .len(ilen), .inc(inc_pc)
  );

  bta_targets #(.AW(AW), .OW(OW), .PW(PW), .DW(DW)) u_tgt (
    .inc(inc_pc), .off(rel_off), .page(page_addr), .acc(acc), .dptr(dptr),
    .t_rel(t_rel), .t_page(t_page), .t_tab(t_tab)
  );

  bta_select #(.AW(AW)) u_sel (
    .kind(kind), .taken(taken), .inc(inc_pc), .t_rel(t_rel), .t_page(t_page),
    .t_long(abs_addr), .t_tab(t_tab), .nxt(nxt_pc), .jump(jump_sel)
  );

  bta_pc_reg #(.AW(AW)) u_pc (
    .clk(clk), .rst(rst), .nxt(nxt_pc), .pc_q(pc_q)
  );

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !taken |=> (pc_q == $past(inc_pc))); // R3
  AST_NO_JUMP_SEQ: assert property (@(posedge clk) disable iff (rst)
    (kind == BK_SEQ) |-> !jump_sel); // R2
  AST_REL_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (taken && kind == BK_REL) |=>
      (((pc_q - $past(inc_pc)) >> (OW - 1)) == '0 ||
       ((pc_q - $past(inc_pc)) >> (OW - 1)) == ({AW{1'b1}} >> (OW - 1)))); // R5
  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (taken && kind == BK_PAGE) |=>
      (pc_q[AW-1:PW] == $past(inc_pc[AW-1:PW]) && pc_q[PW-1:0] == $past(page_addr))); // R6
  AST_LONG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (taken && kind == BK_LONG) |=> (pc_q == $past(abs_addr))); // R7
  AST_TABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (taken && kind == BK_TABLE) |=> (pc_q == $past(t_tab))); // R8
  AST_HI_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (taken && kind == BK_PAGE) |-> (t_page[AW-1:AW-HIW] == inc_pc[AW-1:PW])); // R6
endmodule

// File: tb/bta_nextpc_bench.sv
module bta_nextpc_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  kind;
  logic [1:0]  ilen;
  logic        taken;
  logic [7:0]  rel_off;
  logic [10:0] page_addr;
  logic [15:0] abs_addr;
  logic [7:0]  acc;
  logic [15:0] dptr;
  logic [15:0] pc_q;

  int checks = 0;
  int errors = 0;
  logic [15:0] mpc;
  bit done = 0;

  always #4 clk = ~clk;

  bta_nextpc u_bta_nextpc (
    .clk(clk), .rst(rst), .kind(kind), .ilen(ilen), .taken(taken),
    .rel_off(rel_off), .page_addr(page_addr), .abs_addr(abs_addr),
    .acc(acc), .dptr(dptr), .pc_q(pc_q)
  );

  function automatic logic [15:0] model(input logic [15:0] pc, input logic [2:0] k,
      input logic [1:0] n, input logic t, input logic [7:0] o, input logic [10:0] pg,
      input logic [15:0] ab, input logic [7:0] a, input logic [15:0] dp);
    int unsigned nx;
    int signed so;
    nx = (int'(pc) + int'(n)) % 65536;
    so = (o >= 8'h80) ? int'(o) - 256 : int'(o);
    if (!t) return nx[15:0];
    case (k)
      3'd1: return 16'((int'(nx) + so + 65536) % 65536);
      3'd2: return (nx[15:0] & 16'hF800) | {5'b0, pg};
      3'd3: return ab;
      3'd4: return 16'((int'(dp) + int'(a)) % 65536);
      default: return nx[15:0];
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (pc_q !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, pc_q, exp);
    end
  endtask

  task automatic step(input string req, input logic [2:0] k, input logic [1:0] n,
      input logic t, input logic [7:0] o, input logic [10:0] pg, input logic [15:0] ab,
      input logic [7:0] a, input logic [15:0] dp);
    logic [15:0] e;
    kind = k; ilen = n; taken = t; rel_off = o; page_addr = pg;
    abs_addr = ab; acc = a; dptr = dp;
    e = model(mpc, k, n, t, o, pg, ab, a, dp);
    @(negedge clk);
    mpc = e;
    check(req, e);
  endtask

  task automatic go(input logic [15:0] where);
    step("R7 setup", 3'd3, 2'd3, 1'b1, 8'h00, 11'h0, where, 8'h00, 16'h0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; kind = 3'd3; ilen = 2'd2; taken = 1'b1; rel_off = 8'h0;
    page_addr = 11'h0; abs_addr = 16'hBEEF; acc = 8'h0; dptr = 16'h0;
    @(negedge clk); @(negedge clk);
    mpc = 16'h0000;
    check("R1 reset", 16'h0000);
    rst = 1'b0;

    // R10 / R2: sequential advance
    step("R2 seq len1", 3'd0, 2'd1, 1'b1, 8'h00, 11'h0, 16'h0, 8'h0, 16'h0);
    step("R2 seq len3", 3'd0, 2'd3, 1'b0, 8'h00, 11'h0, 16'h0, 8'h0, 16'h0);
    step("R2 kind5 seq", 3'd5, 2'd2, 1'b1, 8'h7F, 11'h7FF, 16'h1234, 8'h55, 16'h5555);
    step("R2 kind7 seq", 3'd7, 2'd1, 1'b1, 8'h80, 11'h001, 16'hAAAA, 8'h01, 16'h0001);

    // R4 / R5 relative
    go(16'h0100);
    step("R4 rel +5", 3'd1, 2'd2, 1'b1, 8'h05, 11'h0, 16'h0, 8'h0, 16'h0);
    check("R4 rel +5 value", 16'h0107);
    go(16'h0100);
    step("R5 rel FEH", 3'd1, 2'd2, 1'b1, 8'hFE, 11'h0, 16'h0, 8'h0, 16'h0);
    check("R5 rel FEH value", 16'h0100);
    go(16'h1000);
    step("R5 rel -128", 3'd1, 2'd2, 1'b1, 8'h80, 11'h0, 16'h0, 8'h0, 16'h0);
    check("R5 rel -128 value", 16'h0F82);
    go(16'h1000);
    step("R5 rel +127", 3'd1, 2'd3, 1'b1, 8'h7F, 11'h0, 16'h0, 8'h0, 16'h0);
    check("R5 rel +127 value", 16'h1082);

    // R3 not taken for each kind
    go(16'h2000);
    step("R3 rel not taken", 3'd1, 2'd3, 1'b0, 8'h40, 11'h0, 16'h0, 8'h0, 16'h0);
    check("R3 rel nt value", 16'h2003);
    step("R3 long not taken", 3'd3, 2'd3, 1'b0, 8'h00, 11'h0, 16'h9999, 8'h0, 16'h0);
    step("R3 page not taken", 3'd2, 2'd2, 1'b0, 8'h00, 11'h3FF, 16'h0, 8'h0, 16'h0);
    step("R3 table not taken", 3'd4, 2'd1, 1'b0, 8'h00, 11'h0, 16'h0, 8'h10, 16'h4000);
    check("R3 chain value", 16'h2009);

    // R6 page, crossing into next page via increment
    go(16'h07FE);
    step("R6 page cross", 3'd2, 2'd2, 1'b1, 8'h0, 11'h123, 16'h0, 8'h0, 16'h0);
    check("R6 page cross value", 16'h0923);
    go(16'hF800);
    step("R6 top page", 3'd2, 2'd2, 1'b1, 8'h0, 11'h7FF, 16'h0, 8'h0, 16'h0);
    check("R6 top page value", 16'hFFFF);

    // R7 long
    step("R7 long", 3'd3, 2'd3, 1'b1, 8'h0, 11'h0, 16'h4000, 8'h0, 16'h0);
    check("R7 long value", 16'h4000);

    // R8 / R9 table and wrap
    step("R8 table", 3'd4, 2'd1, 1'b1, 8'h02, 11'h0, 16'h0, 8'h02, 16'h3000);
    check("R8 table value", 16'h3002);
    step("R9 table wrap", 3'd4, 2'd1, 1'b1, 8'h0, 11'h0, 16'h0, 8'hFF, 16'hFF80);
    check("R9 table wrap value", 16'h007F);
    go(16'hFFFF);
    step("R9 seq wrap", 3'd0, 2'd1, 1'b1, 8'h0, 11'h0, 16'h0, 8'h0, 16'h0);
    check("R9 seq wrap value", 16'h0000);
    go(16'hFFF0);
    step("R9 rel wrap", 3'd1, 2'd2, 1'b1, 8'h7F, 11'h0, 16'h0, 8'h0, 16'h0);
    check("R9 rel wrap value", 16'h0071);

    // R1 reset mid-run, overriding a taken long jump
    go(16'h5A5A);
    rst = 1'b1;
    @(negedge clk);
    mpc = 16'h0000;
    check("R1 mid reset", 16'h0000);
    rst = 1'b0;

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      step("R10 random", 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
           1'($urandom), 8'($urandom), 11'($urandom), 16'($urandom),
           8'($urandom), 16'($urandom));
    end

    finish_up();
  end
endmodule